// File: doc/BRIEF.md
# Secure Mode Trap Controller

This block keeps the processor's secure-mode flag and one 32-bit word that is both the secure control word and the trap cause record. Secure software reads and writes the word through a simple register port. Two trap sources feed it: a power-button event and a memory-interface error. A third trap comes from any read of the word made outside secure mode. Every new cause raises a one-cycle non-maskable interrupt toward the CPU, which vectors to 0xBFC00000. The handler then reads the word to find out why it was entered. Taking a trap puts the processor back into secure mode.

Every uncached access presents its physical address to the block. The block decodes the boot window pair and the extra SRAM window. It produces one select line per region and a permit flag. When an access to a secure region is denied, its write enable is dropped and its read data is forced to zero. A swap bit chooses which of the two 128 KiB windows holds the boot ROM and which holds the secure kernel RAM. An enable bit opens the 32 KiB SRAM window to code that is not in secure mode.

Top module: `sec_trap_ctl`

## Requirements
- R1: After reset the register at 0x04300014 reads 0x00000003, meaning secure flag (bit 0) = 1 and swap (bit 1) = 1, with every other bit 0. The NMI output is low.
- R2: A write made in secure mode loads bit 0 (secure), bit 1 (swap), bit 24 (SRAM enable) and bit 25 (spare) from the write data. All bits other than 0, 1, 2, 5, 6, 24 and 25 always read 0.
- R3: The cause bits are bit 2 (illegal read), bit 5 (memory-interface error) and bit 6 (button). A secure write of 0 to a cause bit clears it. A write of 1 leaves it unchanged, so software can never set a cause bit.
- R4: A write to the register made while the secure flag is 0 changes nothing.
- R5: A read of the register while the secure flag is 0 returns the current value. It also sets bit 2 and the secure flag, and the NMI is high in the following cycle.
- R6: A button event sets bit 6 and a memory-interface error sets bit 5. Each also sets the secure flag. Events arriving in the same cycle are all recorded, and they produce a single NMI pulse one cycle after the event.
- R7: The NMI is high for exactly one cycle, and only when at least one cause bit went from 0 to 1. An event whose cause bit is already set produces no pulse.
- R8: With swap = 1 the boot ROM select covers 0x1FC00000 to 0x1FC1FFFF and the kernel RAM select covers 0x1FC20000 to 0x1FC3FFFF. With swap = 0 the two windows exchange roles. At most one select is high at a time.
- R9: The SRAM select covers 0x1FC40000 to 0x1FC47FFF. Outside secure mode an access there is permitted only when bit 24 is 1.
- R10: Outside secure mode an access to the ROM or kernel RAM window is denied: the permit flag is low, no select is high, the write enable is low and the read data is zero. Accesses outside all three windows are always permitted and pass read data and write enable through.
- R11: A secure write with bit 0 = 0 takes effect for an access in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Register port access strobe |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 32 | Register port physical address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (zero when not addressed) |
| btn_press | input | 1 | Power-button trap event, one per cycle high |
| mif_err | input | 1 | Memory-interface error trap event |
| nmi | output | 1 | One-cycle non-maskable interrupt request |
| mem_valid | input | 1 | Uncached access present this cycle |
| mem_addr | input | 32 | Physical address of the access |
| mem_we | input | 1 | Access is a write |
| arr_rdata | input | DW | Read data returned by the memory arrays |
| mem_rdata | output | DW | Read data to the CPU, zero when denied |
| arr_we | output | 1 | Write enable to the arrays, dropped when denied |
| sel_rom | output | 1 | Boot ROM selected |
| sel_kram | output | 1 | Secure kernel RAM selected |
| sel_sram | output | 1 | Extra secure SRAM selected |
| mem_permit | output | 1 | Access permitted |

## Verification
The bench sweeps every combination of swap, SRAM enable and secure flag. For each one it probes the first and last word of each window and the words just outside them, and computes the expected selects from the address arithmetic. A swapped or off-by-one decode shows up as a wrong select line. A leaky permit shows up as nonzero read data or a live write enable. The first access after a secure exit is probed in the very next cycle, so a design that delays the exit grants that access. The bench also covers clearing one cause bit while keeping another, simultaneous events and a repeated event with its bit already set. A design that lets software set cause bits, double-pulses the NMI, or pulses it again on a repeat event fails these checks.

// File: rtl/sec_trap_ctl.sv
module sec_trap_ctl #(
  parameter logic [31:0] REG_ADDR  = 32'h0430_0014,
  parameter logic [31:0] WIN_LO    = 32'h1FC0_0000,
  parameter logic [31:0] WIN_HI    = 32'h1FC2_0000,
  parameter int          WIN_BITS  = 17,
  parameter logic [31:0] SRAM_BASE = 32'h1FC4_0000,
  parameter int          SRAM_BITS = 15,
  parameter int          DW        = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_wr,
  input  logic [31:0]   cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          btn_press,
  input  logic          mif_err,
  output logic          nmi,
  input  logic          mem_valid,
  input  logic [31:0]   mem_addr,
  input  logic          mem_we,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] mem_rdata,
  output logic          arr_we,
  output logic          sel_rom,
  output logic          sel_kram,
  output logic          sel_sram,
  output logic          mem_permit
);
  localparam int B_SEC = 0, B_SWAP = 1, B_APP = 2, B_MIF = 5, B_BTN = 6;
  localparam int B_SRAM = 24, B_SPARE = 25;
  localparam logic [31:0] CTL_M   = (32'd1 << B_SEC) | (32'd1 << B_SWAP)
                                  | (32'd1 << B_SRAM) | (32'd1 << B_SPARE);
  localparam logic [31:0] CAUSE_M = (32'd1 << B_APP) | (32'd1 << B_MIF) | (32'd1 << B_BTN);
  localparam logic [31:0] RST_V   = (32'd1 << B_SEC) | (32'd1 << B_SWAP);
  localparam logic [31:0] WIN_M   = ~((32'd1 << WIN_BITS) - 32'd1);
  localparam logic [31:0] SRAM_M  = ~((32'd1 << SRAM_BITS) - 32'd1);

  logic [31:0] reg_q;
  logic        nmi_q;

  wire sec_q   = reg_q[B_SEC];
  wire swap_q  = reg_q[B_SWAP];
  wire sram_en = reg_q[B_SRAM];

  wire reg_hit = cfg_en && (cfg_addr == REG_ADDR);
  wire reg_wr  = reg_hit && cfg_wr && sec_q;
  wire bad_rd  = reg_hit && !cfg_wr && !sec_q;

  wire [31:0] ev_vec = ({31'd0, bad_rd} << B_APP) | ({31'd0, mif_err} << B_MIF)
                     | ({31'd0, btn_press} << B_BTN);
  wire        any_ev = |ev_vec;

  wire [31:0] wr_img = (cfg_wdata & CTL_M) | (reg_q & cfg_wdata & CAUSE_M);
  wire [31:0] base_v = reg_wr ? wr_img : reg_q;
  wire [31:0] reg_nx = base_v | ev_vec | {31'd0, any_ev};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q <= RST_V;
      nmi_q <= 1'b0;
    end else begin
      reg_q <= reg_nx;
      nmi_q <= |(reg_nx & ~reg_q & CAUSE_M);
    end
  end

  assign nmi       = nmi_q;
  assign cfg_rdata = (reg_hit && !cfg_wr) ? reg_q : 32'd0;

  wire in_lo   = (mem_addr & WIN_M)  == (WIN_LO & WIN_M);
  wire in_hi   = (mem_addr & WIN_M)  == (WIN_HI & WIN_M);
  wire in_sram = (mem_addr & SRAM_M) == (SRAM_BASE & SRAM_M);
  wire rom_hit  = swap_q ? in_lo : in_hi;
  wire kram_hit = swap_q ? in_hi : in_lo;
  wire allowed  = sec_q || !(in_lo || in_hi || in_sram) || (in_sram && sram_en);

  assign mem_permit = mem_valid && allowed;
  assign sel_rom    = mem_permit && rom_hit;
  assign sel_kram   = mem_permit && kram_hit;
  assign sel_sram   = mem_permit && in_sram;
  assign arr_we     = mem_we && mem_permit;
  assign mem_rdata  = mem_permit ? arr_rdata : '0;

  // R4
  ign_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_hit && cfg_wr && !sec_q) |=> $stable(swap_q) && $stable(sram_en) && $stable(reg_q[B_SPARE]));
  // R6
  trap_sec_chk: assert property (@(posedge clk) disable iff (!rst_n) nmi_q |-> sec_q);
  // R7
  nmi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_q |-> |(reg_q & ~$past(reg_q) & CAUSE_M));
  // R8
  sel_one_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({sel_rom, sel_kram, sel_sram}));
  // R10
  deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_q && mem_valid && (in_lo || in_hi)) |-> (!mem_permit && !arr_we && mem_rdata == '0));
endmodule

// File: tb/sec_trap_ctl_bench.sv
module sec_trap_ctl_bench;
  localparam int CLK_P = 10;
  localparam logic [31:0] RA = 32'h0430_0014;

  logic clk = 0, rst_n = 0;
  logic cfg_en = 0, cfg_wr = 0;
  logic [31:0] cfg_addr = RA, cfg_wdata = 0, cfg_rdata;
  logic btn_press = 0, mif_err = 0, nmi;
  logic mem_valid = 0, mem_we = 0;
  logic [31:0] mem_addr = 0, arr_rdata = 0, mem_rdata;
  logic arr_we, sel_rom, sel_kram, sel_sram, mem_permit;
  int total = 0, bad = 0;

  sec_trap_ctl u_sec_trap_ctl (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [31:0] d);
    @(negedge clk); cfg_en = 1; cfg_wr = 1; cfg_wdata = d;
    @(negedge clk); cfg_en = 0; cfg_wr = 0;
  endtask

  task automatic cfg_read(output logic [31:0] d);
    @(negedge clk); cfg_en = 1; cfg_wr = 0; #1 d = cfg_rdata;
    @(negedge clk); cfg_en = 0;
  endtask

  task automatic events(logic b, logic m);
    @(negedge clk); btn_press = b; mif_err = m;
    @(negedge clk); btn_press = 0; mif_err = 0;
  endtask

  task automatic probe(logic [31:0] a, logic sw, logic se, logic sec);
    logic lo, hi, sr, ok;
    string tag;
    lo = (a >> 17) == (32'h1FC0_0000 >> 17);
    hi = (a >> 17) == (32'h1FC2_0000 >> 17);
    sr = (a >> 15) == (32'h1FC4_0000 >> 15);
    ok = sec || !(lo || hi || sr) || (sr && se);
    tag = sr ? "R9" : ((lo || hi) ? (sec ? "R8" : "R10") : "R10");
    mem_valid = 1; mem_we = 1; mem_addr = a; arr_rdata = a ^ 32'h5A5A_0000;
    #1;
    chk(tag, {27'd0, sel_rom, sel_kram, sel_sram, mem_permit, arr_we},
        {27'd0, ok && (sw ? lo : hi), ok && (sw ? hi : lo), ok && sr, ok, ok});
    chk(tag, mem_rdata, ok ? (a ^ 32'h5A5A_0000) : 32'd0);
    #1 mem_valid = 0; mem_we = 0;
  endtask

  initial begin
    #(CLK_P * 50000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [31:0] addrs [10] = '{32'h1FC0_0000, 32'h1FC1_FFFC, 32'h1FC2_0000, 32'h1FC3_FFFC,
                              32'h1FC4_0000, 32'h1FC4_7FFC, 32'h1FC4_8000, 32'h1FBF_FFFC,
                              32'h0430_0014, 32'h0000_1000};

  initial begin
    logic [31:0] r, v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk("R1 nmi", {31'd0, nmi}, 0);
    cfg_read(r); chk("R1", r, 32'h0000_0003);

    cfg_write(32'h0300_0003); cfg_read(r); chk("R2", r, 32'h0300_0003);
    cfg_write(32'hFFFF_FFFF); cfg_read(r); chk("R3 no sw set", r, 32'h0300_0003);
    cfg_write(32'h0000_0003); cfg_read(r); chk("R2 clear", r, 32'h0000_0003);

    events(1, 0); chk("R6 nmi", {31'd0, nmi}, 1);
    cfg_read(r); chk("R7 one pulse", {31'd0, nmi}, 0); chk("R6 btn", r, 32'h0000_0043);
    events(0, 1); chk("R6 nmi mif", {31'd0, nmi}, 1);
    cfg_read(r); chk("R6 mif", r, 32'h0000_0063);
    events(1, 0); chk("R7 repeat", {31'd0, nmi}, 0);
    cfg_write(32'h0000_0003); cfg_read(r); chk("R3 clear", r, 32'h0000_0003);
    events(1, 1); chk("R6 both nmi", {31'd0, nmi}, 1);
    @(negedge clk); chk("R7 single", {31'd0, nmi}, 0);
    cfg_read(r); chk("R6 both", r, 32'h0000_0063);
    cfg_write(32'h0000_0043); cfg_read(r); chk("R3 keep", r, 32'h0000_0043);
    cfg_write(32'h0000_0001); cfg_read(r); chk("R3 clear all", r, 32'h0000_0001);

    for (int k = 0; k < 4; k++) begin
      logic sw, se;
      sw = k[0]; se = k[1];
      v = ({31'd0, se} << 24) | ({31'd0, sw} << 1);
      cfg_write(v | 32'd1);
      for (int i = 0; i < 10; i++) begin probe(addrs[i], sw, se, 1); @(negedge clk); end
      cfg_write(v);
      probe(32'h1FC0_0000, sw, se, 0);
      chk("R11", {31'd0, mem_permit}, 0);
      for (int i = 0; i < 10; i++) begin @(negedge clk); probe(addrs[i], sw, se, 0); end
      cfg_write(v ^ 32'h0300_0003);
      cfg_read(r); chk("R4", r, v);
      chk("R5 nmi", {31'd0, nmi}, 1);
      cfg_read(r); chk("R5", r, v | 32'h5);
      cfg_write(v | 32'd1); cfg_read(r); chk("R3 app clear", r, v | 32'd1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule